// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Controller

This block is the per-CPU take-and-retire engine of an interrupt controller. A separate priority search supplies the highest-pending source ID, its priority and whether it is delivered one-of-N. An acknowledge request either grants that ID, making it the running interrupt, or answers with the spurious ID 1023. An end-of-interrupt request retires an ID. The running ID and the running priority are held here. The block also issues strobes that clear or re-set pending bits in the surrounding distributor.

Nesting is kept as a table with one link per source. Each link holds the ID that was running when that source was taken. Retiring the running ID pops to its link. Retiring an ID that is deeper in the nest starts a multi-cycle walk from the running ID. The walk finds the entry that points at the retired ID and bridges over it. While the walk runs, `busy` is high and both request channels refuse new requests.

The acknowledge and end-of-interrupt channels are valid/ready. A request is taken on a rising clock edge where both valid and ready are high. The requester must hold valid and its data until then. The acknowledge answer appears as a one-cycle pulse on `ack_rsp_valid` in the cycle after acceptance, and it cannot be stalled. The lookup ports (`pred_*`, `cpl_*`) are combinational. The distributor answers them in the same cycle.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, `run_id` is 1023, `run_prio` is 0x100 (9 bits), `busy` is low, and no response or pending strobe is active.
- R2: An accepted acknowledge is refused when `hp_id` is 1023 or `hp_prio` is not strictly below `run_prio`. A refused acknowledge answers 1023, raises no clear strobe, and leaves `run_id` and `run_prio` unchanged.
- R3: An accepted acknowledge that is not refused answers `hp_id`. It raises `pend_clr_valid` with `pend_clr_id` = `hp_id`, and it makes `run_id` = `hp_id` and `run_prio` = `hp_prio`.
- R4: On a granted acknowledge, `pend_clr_all` equals `hp_bcast`: 1 clears the pending bit for every CPU, 0 clears it for this CPU only.
- R5: An end-of-interrupt request is ignored when its ID is at or above NUM_SRC, or when `run_id` is 1023. An ignored request raises no set strobe and changes no running state.
- R6: Retiring the running ID makes `run_id` equal the ID that was running when it was taken. `run_prio` becomes that ID's priority, or 0x100 if that ID is 1023.
- R7: Retiring a non-running ID that is in the nest removes it from the nest and leaves `run_id` and `run_prio` unchanged. Later pops skip the removed ID.
- R8: An end-of-interrupt request that is not ignored raises `pend_set_valid` with its ID one cycle after acceptance when the source is level-sensitive (`cpl_edge` = 0), enabled, asserted and targeted at this CPU. Otherwise no set strobe is raised.
- R9: The end-of-interrupt ID is `eoi_data[9:0]`. Bits 31:10 have no effect.
- R10: While a nest walk runs, `busy` is high and both `eoi_ready` and `ack_ready` are low.
- R11: When both request channels are valid in the same cycle while idle, the end-of-interrupt request is taken. `ack_ready` is low in that cycle, and no acknowledge answer follows it.
- R12: `ack_rsp_valid` is a single-cycle pulse in the cycle after each accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_id | input | 10 | Highest-pending source ID, 1023 for none |
| hp_prio | input | 8 | Priority of `hp_id`, lower value is more urgent |
| hp_bcast | input | 1 | `hp_id` is delivered one-of-N (clear for all CPUs) |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge request can be taken |
| ack_rsp_valid | output | 1 | Acknowledge answer pulse |
| ack_rsp_id | output | 10 | Granted ID or 1023 |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_ready | output | 1 | End-of-interrupt request can be taken |
| eoi_data | input | 32 | End-of-interrupt word, ID in bits 9:0 |
| pred_id | output | 10 | Stored predecessor of the running ID (priority lookup address) |
| pred_prio | input | 8 | Priority of `pred_id` |
| cpl_id | output | 10 | ID of the end-of-interrupt request (attribute lookup address) |
| cpl_edge | input | 1 | `cpl_id` is edge-triggered |
| cpl_enabled | input | 1 | `cpl_id` is enabled for this CPU |
| cpl_level | input | 1 | `cpl_id` input is asserted |
| cpl_targeted | input | 1 | `cpl_id` targets this CPU |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | 9 | Running priority, 0x100 when idle |
| busy | output | 1 | Nest walk in progress |
| pend_clr_valid | output | 1 | Pending-clear strobe |
| pend_clr_id | output | 10 | ID to clear |
| pend_clr_all | output | 1 | Clear for all CPUs |
| pend_set_valid | output | 1 | Pending re-set strobe |
| pend_set_id | output | 10 | ID to set pending |

## Verification
An acknowledge and an end-of-interrupt request can arrive in the same cycle, and only one may change the running state. The bench raises both valids on the same falling edge while idle. It checks that `ack_ready` is low before the edge and that no acknowledge answer follows it. It checks that the running state matches the model of the retire alone, and that the held acknowledge is granted or refused afterwards against the updated running priority. Nested takes and retires that come out of order are also driven at random. Each walk's end state is compared with a bench linked-list model.

// File: rtl/irqack_pkg.sv
package irqack_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;
  typedef logic [ID_W-1:0] irq_id_t;
  typedef enum logic {WK_IDLE, WK_STEP} walk_state_e;
endpackage

// File: rtl/irqack_link_table.sv
module irqack_link_table
  import irqack_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  irq_id_t wr_addr,
  input  irq_id_t wr_data,
  input  irq_id_t rd_a_addr,
  output irq_id_t rd_a_data,
  input  irq_id_t rd_b_addr,
  output irq_id_t rd_b_data,
  input  irq_id_t rd_c_addr,
  output irq_id_t rd_c_data
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam irq_id_t SRC_LIM = irq_id_t'(NUM_SRC);

  irq_id_t links [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        links[g] <= NO_IRQ;
      end else if (wr_en && wr_addr == irq_id_t'(g)) begin
        links[g] <= wr_data;
      end
    end
  end

  function automatic irq_id_t look(input irq_id_t a);
    if (a < SRC_LIM) return links[a[IDX_W-1:0]];
    return NO_IRQ;
  endfunction

  assign rd_a_data = look(rd_a_addr);
  assign rd_b_data = look(rd_b_addr);
  assign rd_c_data = look(rd_c_addr);

  // R3
  link_write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < SRC_LIM));
endmodule

// File: rtl/irqack_ack_gate.sv
module irqack_ack_gate
  import irqack_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  irq_id_t           hp_id,
  input  logic [PRIO_W-1:0] hp_prio,
  input  logic              hp_bcast,
  input  logic [PRIO_W:0]   run_prio,
  output logic              grant,
  output logic              rsp_valid,
  output irq_id_t           rsp_id,
  output logic              clr_valid,
  output irq_id_t           clr_id,
  output logic              clr_all
);
  assign grant = (hp_id != NO_IRQ) && ({1'b0, hp_prio} < run_prio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= NO_IRQ;
      clr_valid <= 1'b0;
      clr_id    <= NO_IRQ;
      clr_all   <= 1'b0;
    end else begin
      rsp_valid <= take;
      clr_valid <= take && grant;
      if (take) begin
        rsp_id <= grant ? hp_id : NO_IRQ;
      end
      if (take && grant) begin
        clr_id  <= hp_id;
        clr_all <= hp_bcast;
      end
    end
  end

  // R3
  grant_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && grant) |=> (rsp_valid && clr_valid && rsp_id == $past(hp_id)
                         && clr_all == $past(hp_bcast)));
  // R2
  refuse_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !grant) |=> (rsp_valid && !clr_valid && rsp_id == NO_IRQ));
endmodule

// File: rtl/irqack_chain_walker.sv
module irqack_chain_walker
  import irqack_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  irq_id_t start_cursor,
  input  irq_id_t start_target,
  input  irq_id_t link_at_cursor,
  input  irq_id_t link_at_target,
  output logic    busy,
  output irq_id_t cursor,
  output irq_id_t target,
  output logic    splice_en,
  output irq_id_t splice_addr,
  output irq_id_t splice_data
);
  walk_state_e state_q;

  assign busy        = (state_q == WK_STEP);
  assign splice_en   = busy && (link_at_cursor != NO_IRQ) && (link_at_cursor == target);
  assign splice_addr = cursor;
  assign splice_data = link_at_target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      cursor  <= NO_IRQ;
      target  <= NO_IRQ;
    end else begin
      unique case (state_q)
        WK_IDLE: begin
          if (start) begin
            state_q <= WK_STEP;
            cursor  <= start_cursor;
            target  <= start_target;
          end
        end
        WK_STEP: begin
          if (link_at_cursor == NO_IRQ || link_at_cursor == target) begin
            state_q <= WK_IDLE;
          end else begin
            cursor <= link_at_cursor;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  // R7
  step_cursor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cursor != NO_IRQ && cursor != target));
  // R10
  walk_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !splice_en && link_at_cursor != NO_IRQ) |=> (busy && $stable(target)));
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irqack_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        hp_id,
  input  logic [PRIO_W-1:0] hp_prio,
  input  logic              hp_bcast,
  input  logic              ack_valid,
  output logic              ack_ready,
  output logic              ack_rsp_valid,
  output logic [9:0]        ack_rsp_id,
  input  logic              eoi_valid,
  output logic              eoi_ready,
  input  logic [31:0]       eoi_data,
  output logic [9:0]        pred_id,
  input  logic [PRIO_W-1:0] pred_prio,
  output logic [9:0]        cpl_id,
  input  logic              cpl_edge,
  input  logic              cpl_enabled,
  input  logic              cpl_level,
  input  logic              cpl_targeted,
  output logic [9:0]        run_id,
  output logic [PRIO_W:0]   run_prio,
  output logic              busy,
  output logic              pend_clr_valid,
  output logic [9:0]        pend_clr_id,
  output logic              pend_clr_all,
  output logic              pend_set_valid,
  output logic [9:0]        pend_set_id
);
  localparam irq_id_t SRC_LIM = irq_id_t'(NUM_SRC);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic    ack_take, eoi_take, eoi_live, eoi_pop, eoi_walk, grant, ack_win;
  logic    repend;
  irq_id_t eoi_id;
  irq_id_t walk_cursor, walk_target, link_cursor, link_target;
  logic    splice_en;
  irq_id_t splice_addr, splice_data;
  logic    tbl_wr_en;
  irq_id_t tbl_wr_addr, tbl_wr_data;

  assign eoi_ready = !busy;
  assign ack_ready = !busy && !eoi_valid;
  assign eoi_take  = eoi_valid && eoi_ready;
  assign ack_take  = ack_valid && ack_ready;
  assign eoi_id    = eoi_data[ID_W-1:0];
  assign cpl_id    = eoi_id;
  assign eoi_live  = eoi_take && (eoi_id < SRC_LIM) && (run_id != NO_IRQ);
  assign eoi_pop   = eoi_live && (eoi_id == run_id);
  assign eoi_walk  = eoi_live && (eoi_id != run_id);
  assign ack_win   = ack_take && grant;
  assign repend    = eoi_live && !cpl_edge && cpl_enabled && cpl_level && cpl_targeted;

  irqack_ack_gate #(.PRIO_W(PRIO_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (ack_take),
    .hp_id     (hp_id),
    .hp_prio   (hp_prio),
    .hp_bcast  (hp_bcast),
    .run_prio  (run_prio),
    .grant     (grant),
    .rsp_valid (ack_rsp_valid),
    .rsp_id    (ack_rsp_id),
    .clr_valid (pend_clr_valid),
    .clr_id    (pend_clr_id),
    .clr_all   (pend_clr_all)
  );

  always_comb begin
    if (ack_win) begin
      tbl_wr_en   = 1'b1;
      tbl_wr_addr = hp_id;
      tbl_wr_data = run_id;
    end else begin
      tbl_wr_en   = splice_en;
      tbl_wr_addr = splice_addr;
      tbl_wr_data = splice_data;
    end
  end

  irqack_link_table #(.NUM_SRC(NUM_SRC)) u_links (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_wr_en),
    .wr_addr   (tbl_wr_addr),
    .wr_data   (tbl_wr_data),
    .rd_a_addr (run_id),
    .rd_a_data (pred_id),
    .rd_b_addr (walk_cursor),
    .rd_b_data (link_cursor),
    .rd_c_addr (walk_target),
    .rd_c_data (link_target)
  );

  irqack_chain_walker u_walk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (eoi_walk),
    .start_cursor   (run_id),
    .start_target   (eoi_id),
    .link_at_cursor (link_cursor),
    .link_at_target (link_target),
    .busy           (busy),
    .cursor         (walk_cursor),
    .target         (walk_target),
    .splice_en      (splice_en),
    .splice_addr    (splice_addr),
    .splice_data    (splice_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_id         <= NO_IRQ;
      run_prio       <= IDLE_PRIO;
      pend_set_valid <= 1'b0;
      pend_set_id    <= NO_IRQ;
    end else begin
      if (ack_win) begin
        run_id   <= hp_id;
        run_prio <= {1'b0, hp_prio};
      end else if (eoi_pop) begin
        run_id   <= pred_id;
        run_prio <= (pred_id == NO_IRQ) ? IDLE_PRIO : {1'b0, pred_prio};
      end
      pend_set_valid <= repend;
      if (repend) pend_set_id <= eoi_id;
    end
  end

  // R1
  idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == NO_IRQ) |-> (run_prio == IDLE_PRIO));
  // R6
  eoi_pop_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pop |=> (run_id == $past(pred_id)));
  // R5
  eoi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_take && !eoi_live) |=> ($stable(run_id) && $stable(run_prio) && !pend_set_valid));
  // R11
  eoi_over_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && ack_valid && !busy) |=> !ack_rsp_valid);
  // R7
  walk_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(run_id));
endmodule

// File: tb/tb_irq_ack_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ack_ctrl;
  localparam int NSRC = 64;
  localparam logic [9:0] SPUR = 10'd1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [9:0] hp_id = SPUR;
  logic [7:0] hp_prio = 8'hFF;
  logic hp_bcast = 1'b0, ack_valid = 1'b0, eoi_valid = 1'b0;
  logic [31:0] eoi_data = '0;
  logic ack_ready, ack_rsp_valid, eoi_ready, busy;
  logic [9:0] ack_rsp_id, pred_id, cpl_id, run_id, pend_clr_id, pend_set_id;
  logic [7:0] pred_prio;
  logic cpl_edge, cpl_enabled, cpl_level, cpl_targeted;
  logic [8:0] run_prio;
  logic pend_clr_valid, pend_clr_all, pend_set_valid;

  logic [7:0] prio_tab [NSRC];
  logic bc_tab [NSRC];
  logic edge_tab [NSRC];
  logic en_tab [NSRC];
  logic lvl_tab [NSRC];
  logic tgt_tab [NSRC];

  assign pred_prio    = (pred_id < NSRC) ? prio_tab[pred_id[5:0]] : 8'h00;
  assign cpl_edge     = (cpl_id < NSRC) ? edge_tab[cpl_id[5:0]] : 1'b0;
  assign cpl_enabled  = (cpl_id < NSRC) ? en_tab[cpl_id[5:0]] : 1'b0;
  assign cpl_level    = (cpl_id < NSRC) ? lvl_tab[cpl_id[5:0]] : 1'b0;
  assign cpl_targeted = (cpl_id < NSRC) ? tgt_tab[cpl_id[5:0]] : 1'b0;

  irq_ack_ctrl #(.NUM_SRC(NSRC), .PRIO_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .hp_id(hp_id), .hp_prio(hp_prio), .hp_bcast(hp_bcast),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_rsp_valid(ack_rsp_valid),
    .ack_rsp_id(ack_rsp_id), .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
    .eoi_data(eoi_data), .pred_id(pred_id), .pred_prio(pred_prio), .cpl_id(cpl_id),
    .cpl_edge(cpl_edge), .cpl_enabled(cpl_enabled), .cpl_level(cpl_level),
    .cpl_targeted(cpl_targeted), .run_id(run_id), .run_prio(run_prio), .busy(busy),
    .pend_clr_valid(pend_clr_valid), .pend_clr_id(pend_clr_id),
    .pend_clr_all(pend_clr_all), .pend_set_valid(pend_set_valid),
    .pend_set_id(pend_set_id)
  );

  int n_chk = 0, n_fail = 0;
  logic [9:0] m_link [NSRC];
  bit m_active [NSRC];
  logic [9:0] m_run = SPUR;
  logic [8:0] m_prio = 9'h100;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] prio_of(input logic [9:0] id);
    return (id == SPUR) ? 9'h100 : {1'b0, prio_tab[id[5:0]]};
  endfunction

  function automatic void m_retire(input logic [9:0] id);
    logic [9:0] cur, nxt;
    if (id == m_run) begin
      m_active[id[5:0]] = 1'b0;
      m_run  = m_link[id[5:0]];
      m_prio = prio_of(m_run);
    end else begin
      cur = m_run;
      for (int k = 0; k <= NSRC; k++) begin
        nxt = m_link[cur[5:0]];
        if (nxt == SPUR) break;
        if (nxt == id) begin
          m_link[cur[5:0]] = m_link[id[5:0]];
          m_active[id[5:0]] = 1'b0;
          break;
        end
        cur = nxt;
      end
    end
  endfunction

  task automatic check_run(input string tag);
    chk(run_id == m_run, tag, run_id, m_run);
    chk(run_prio == m_prio, tag, run_prio, m_prio);
  endtask

  task automatic do_ack(input logic [9:0] id);
    bit win;
    @(negedge clk);
    hp_id    = id;
    hp_prio  = (id < NSRC) ? prio_tab[id[5:0]] : 8'hFF;
    hp_bcast = (id < NSRC) ? bc_tab[id[5:0]] : 1'b0;
    ack_valid = 1'b1;
    win = (id != SPUR) && ({1'b0, hp_prio} < m_prio);
    @(posedge clk);
    @(negedge clk);
    ack_valid = 1'b0;
    // R12 answer pulse one cycle after acceptance
    chk(ack_rsp_valid == 1'b1, "R12 rsp pulse", ack_rsp_valid, 1);
    // R2 / R3 answer value and clear strobe
    chk(ack_rsp_id == (win ? id : SPUR), win ? "R3 grant id" : "R2 refuse id", ack_rsp_id, win ? id : SPUR);
    chk(pend_clr_valid == win, win ? "R3 clr strobe" : "R2 no clr", pend_clr_valid, win);
    if (win) begin
      chk(pend_clr_id == id, "R3 clr id", pend_clr_id, id);
      // R4 clear scope follows one-of-N attribute
      chk(pend_clr_all == hp_bcast, "R4 clr scope", pend_clr_all, hp_bcast);
      m_link[id[5:0]] = m_run;
      m_active[id[5:0]] = 1'b1;
      m_run = id;
      m_prio = {1'b0, hp_prio};
    end
    check_run(win ? "R3 running" : "R2 unchanged");
    @(negedge clk);
    chk(ack_rsp_valid == 1'b0, "R12 single pulse", ack_rsp_valid, 0);
  endtask

  task automatic finish_eoi(input logic [31:0] data, input bit walk_ready_chk);
    logic [9:0] id;
    bit live, setx, walks;
    int waited;
    id = data[9:0];
    live = (id < NSRC) && (m_run != SPUR);
    setx = live && !edge_tab[id[5:0]] && en_tab[id[5:0]] && lvl_tab[id[5:0]] && tgt_tab[id[5:0]];
    walks = live && (id != m_run);
    @(posedge clk);
    @(negedge clk);
    eoi_valid = 1'b0;
    // R8 re-pend strobe (R5: none when ignored)
    chk(pend_set_valid == setx, live ? "R8 set strobe" : "R5 ignored no set", pend_set_valid, setx);
    if (setx) chk(pend_set_id == id, "R8 set id", pend_set_id, id);
    if (walks && walk_ready_chk) begin
      // R10 readiness low during the walk
      chk(busy == 1'b1, "R10 busy", busy, 1);
      chk(eoi_ready == 1'b0 && ack_ready == 1'b0, "R10 ready low", {eoi_ready, ack_ready}, 0);
    end
    if (live) m_retire(id);
    waited = 0;
    while (busy && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk(busy == 1'b0, "R10 walk ends", busy, 0);
    check_run(!live ? "R5 ignored state" : (walks ? "R7 walk state" : "R6 pop state"));
  endtask

  task automatic do_eoi(input logic [31:0] data);
    @(negedge clk);
    eoi_valid = 1'b1;
    eoi_data = data;
    finish_eoi(data, 1'b1);
  endtask

  int cycles = 0;
  bit done = 1'b0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [9:0] pick;
    logic [31:0] word;
    int r, s;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NSRC; i++) begin
      prio_tab[i] = 8'($urandom_range(0, 255));
      bc_tab[i]   = 1'($urandom);
      edge_tab[i] = 1'($urandom);
      en_tab[i]   = 1'($urandom);
      lvl_tab[i]  = 1'($urandom);
      tgt_tab[i]  = 1'($urandom);
      m_link[i]   = SPUR;
      m_active[i] = 1'b0;
    end
    prio_tab[5] = 8'h80; edge_tab[5] = 1'b1; bc_tab[5] = 1'b1;
    prio_tab[9] = 8'h40; lvl_tab[9] = 1'b0; bc_tab[9] = 1'b0;
    prio_tab[12] = 8'h20; edge_tab[12] = 1'b0; en_tab[12] = 1'b1;
    lvl_tab[12] = 1'b1; tgt_tab[12] = 1'b1;
    prio_tab[20] = 8'h30;
    prio_tab[3] = 8'h10;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(run_id == SPUR, "R1 run id", run_id, SPUR);
    chk(run_prio == 9'h100, "R1 run prio", run_prio, 9'h100);
    chk(busy == 1'b0 && ack_rsp_valid == 1'b0 && pend_clr_valid == 1'b0 && pend_set_valid == 1'b0,
        "R1 idle outputs", {busy, ack_rsp_valid, pend_clr_valid, pend_set_valid}, 0);

    do_ack(SPUR);           // R2 nothing pending
    do_ack(10'd5);          // R3, R4 broadcast clear
    do_ack(10'd9);          // R3 nest
    do_ack(10'd12);         // R3 nest deeper
    do_ack(10'd20);         // R2 priority not strictly lower
    do_eoi(32'h0000_0009);  // R7 splice out of the middle
    do_eoi(32'h0000_000C);  // R6 pop, R8 re-pend, R7 skips 9
    do_eoi(32'h0000_0064);  // R5 out of range
    do_eoi(32'hABC0_0005);  // R9 upper bits ignored, R6 back to idle
    do_eoi(32'h0000_0007);  // R5 nothing running

    // R11 simultaneous requests: retire wins
    do_ack(10'd5);
    @(negedge clk);
    hp_id = 10'd3; hp_prio = prio_tab[3]; hp_bcast = bc_tab[3];
    ack_valid = 1'b1;
    eoi_valid = 1'b1;
    eoi_data = 32'h0000_0005;
    #1;
    chk(ack_ready == 1'b0, "R11 ack held off", ack_ready, 0);
    @(posedge clk);
    #1;
    chk(ack_rsp_valid == 1'b0, "R11 no answer", ack_rsp_valid, 0);
    ack_valid = 1'b0;
    m_retire(10'd5);
    @(negedge clk);
    eoi_valid = 1'b0;
    check_run("R11 retire only");
    do_ack(10'd3);

    // Random nested traffic
    for (int it = 0; it < 400; it++) begin
      r = $urandom_range(0, 99);
      if (r < 50) begin
        pick = ($urandom_range(0, 7) == 0) ? SPUR : 10'($urandom_range(0, NSRC - 1));
        if (pick != SPUR && m_active[pick[5:0]]) pick = SPUR;
        do_ack(pick);
      end else begin
        s = $urandom_range(0, 9);
        pick = 10'($urandom_range(0, NSRC - 1));
        if (s < 6) begin
          for (int k = 0; k < NSRC; k++) begin
            if (m_active[(pick + 10'(k)) % NSRC]) begin
              pick = (pick + 10'(k)) % NSRC;
              break;
            end
          end
        end else if (s < 8) begin
          pick = 10'($urandom_range(NSRC, 1023));
        end
        word = {22'($urandom), pick};
        do_eoi(word);  // R5 R6 R7 R8 R9
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule